// File: doc/BRIEF.md
# Quadrature Lock-In Demodulator Core

This block forms the signal path of a digital lock-in measurement. Each accepted ADC sample is multiplied by two reference samples, one in phase and one shifted by a quarter period, so two mixed products come out. Each product then passes through its own first-order recursive low-pass that behaves like an analog RC stage. The smoothed in-phase (X) and quadrature (Y) results leave the block with a valid strobe.

A control processor sets the time constant by writing a pair of coefficients. For a decay to 1/e in d clock ticks, the pair is b1 = exp(-1/d) and a0 = 1 - b1. A write may arrive at any moment while samples stream. The pair waits in a holding register and becomes active as one unit, so the filter never runs with one old and one new coefficient. All multiplies fit an 18x18 signed hardware multiplier. The target is a 50 MHz clock with input tones up to a few MHz.

Top module: `lockin_demod`

## Requirements
- R1: On a cycle with `in_valid` high, each channel forms the full signed product of `in_sample` and its reference (`ref_i` for X, `ref_q` for Y). The channel's filter input is that product shifted right arithmetically by 14, which is floor(product / 16384).
- R2: The filter state is an 18-bit signed value with 2 fractional guard bits. One step computes state' = floor((a0·x·4 + b1·state) / 131072). Each output equals floor(state / 4).
- R3: If a step's result lies outside [-131072, 131071], the state saturates to the nearest bound. The output then reads 32767 or -32768 and does not wrap.
- R4: Coefficients are unsigned Q0.17 (a value of 131072 would mean 1.0). A pulse on `cfg_we` captures `cfg_a0` and `cfg_b1` together into holding registers. The pair becomes active at the first `in_valid` cycle after the write cycle. Samples presented in a later cycle than the write use the new pair. A sample in the same cycle as the write still uses the old pair.
- R5: After reset, `out_valid` is low, both outputs are zero, and the active pair is a0 = b1 = 65536 (0.5 each).
- R6: `out_valid` goes high exactly two clock edges after an `in_valid` cycle, for one cycle per sample. X and Y change at that same edge.
- R7: Without `in_valid`, the filter states and outputs hold their values, whatever the other inputs do. A coefficient write alone does not change them either.
- R8: `clr` zeroes both filter states at the next edge. It wins over a filter step that falls in the same cycle and does not suppress that step's `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of both filter states |
| in_valid | input | 1 | Sample and references on this cycle are accepted |
| in_sample | input | 14 | Signed ADC sample |
| ref_i | input | 16 | Signed in-phase reference sample |
| ref_q | input | 16 | Signed quadrature reference sample |
| cfg_we | input | 1 | Capture a coefficient pair |
| cfg_a0 | input | 17 | Input-weight coefficient, unsigned Q0.17 |
| cfg_b1 | input | 17 | Feedback coefficient, unsigned Q0.17 |
| out_valid | output | 1 | X and Y were updated at this edge |
| out_x | output | 16 | Signed filtered in-phase result |
| out_y | output | 16 | Signed filtered quadrature result |

## Verification
Several properties are checked on every cycle: the two-edge valid latency and the silence when no sample enters, filter states that hold without a step, zero states after a clear, and active coefficients that change only on a sample cycle. The numeric behaviour can only be shown by the bench's scenarios. These cover the floor-shifted mixing, the recurrence with guard bits, saturation at both rails, and the exact sample at which a newly written pair takes effect, including a write in the same cycle as a sample. The bench compares every result against its own arithmetic model.

// File: rtl/lockin_pkg.sv
package lockin_pkg;
   // channel slots in the packed reference and product buses
   localparam int NUM_CH = 2;
   localparam int CH_X   = 0;
   localparam int CH_Y   = 1;
   // largest operand a single hardware multiplier accepts
   localparam int HW_MUL_W = 18;
endpackage

// File: rtl/lockin_mixer.sv
module lockin_mixer #(
   parameter int SAMPLE_W = 14,
   parameter int REF_W    = 16,
   parameter int FILT_W   = 16,
   parameter int NCH      = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic [NCH*REF_W-1:0]       ref_bus,
   output logic                       mix_valid,
   output logic [NCH*FILT_W-1:0]      mix_bus
);
   localparam int PROD_W = SAMPLE_W + REF_W;
   localparam int DROP   = PROD_W - FILT_W;

   generate
      if (DROP < 0) begin : g_bad_drop
         $error("lockin_mixer: FILT_W wider than the full product");
      end
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic signed [REF_W-1:0]  ref_s;
         logic signed [FILT_W-1:0] prod_q;
         assign ref_s = $signed(ref_bus[c*REF_W +: REF_W]);
         always_ff @(posedge clk) begin
            if (rst)
               prod_q <= '0;
            else if (in_valid)
               prod_q <= FILT_W'((PROD_W'(sample) * PROD_W'(ref_s)) >>> DROP);
         end
         assign mix_bus[c*FILT_W +: FILT_W] = prod_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) mix_valid <= 1'b0;
      else     mix_valid <= in_valid;
   end

   // R7: mixed products only move on an accepted sample
   p_mix_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(mix_bus));
endmodule

// File: rtl/lockin_coef_bank.sv
module lockin_coef_bank #(
   parameter int COEF_W  = 17,
   parameter int A0_INIT = 65536,
   parameter int B1_INIT = 65536
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [COEF_W-1:0] cfg_a0,
   input  logic [COEF_W-1:0] cfg_b1,
   input  logic              in_valid,
   output logic [COEF_W-1:0] a0_act,
   output logic [COEF_W-1:0] b1_act
);
   localparam logic [COEF_W-1:0] A0_RST = COEF_W'(A0_INIT);
   localparam logic [COEF_W-1:0] B1_RST = COEF_W'(B1_INIT);

   logic [COEF_W-1:0] a0_hold, b1_hold;
   logic              pending;

   always_ff @(posedge clk) begin
      if (rst) begin
         a0_hold <= A0_RST;
         b1_hold <= B1_RST;
         a0_act  <= A0_RST;
         b1_act  <= B1_RST;
         pending <= 1'b0;
      end else begin
         if (in_valid && pending) begin
            a0_act  <= a0_hold;
            b1_act  <= b1_hold;
            pending <= 1'b0;
         end
         if (cfg_we) begin
            a0_hold <= cfg_a0;
            b1_hold <= cfg_b1;
            pending <= 1'b1;
         end
      end
   end

   // R4: the active pair changes only at an accepted sample
   p_commit_on_sample_r4: assert property (@(posedge clk) disable iff (rst)
      !($stable(a0_act) && $stable(b1_act)) |-> $past(in_valid));
   // R4: a write with no sample pending leaves the active pair alone
   p_write_deferred_r4: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && !in_valid) |=> ($stable(a0_act) && $stable(b1_act)));
endmodule

// File: rtl/lockin_iir.sv
module lockin_iir #(
   parameter int FILT_W = 16,
   parameter int COEF_W = 17,
   parameter int GUARD  = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     clr,
   input  logic                     step,
   input  logic signed [FILT_W-1:0] x,
   input  logic [COEF_W-1:0]        a0,
   input  logic [COEF_W-1:0]        b1,
   output logic signed [FILT_W-1:0] y
);
   localparam int STATE_W = FILT_W + GUARD;
   localparam int ACC_W   = COEF_W + STATE_W + 3;
   localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((64'sd1 <<< (STATE_W - 1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] SMIN = ACC_W'(-(64'sd1 <<< (STATE_W - 1)));

   logic signed [STATE_W-1:0]       state, nxt;
   logic signed [COEF_W:0]          ca, cb;
   logic signed [COEF_W+FILT_W:0]   pa;
   logic signed [COEF_W+STATE_W:0]  pb;
   logic signed [ACC_W-1:0]         acc, shr;

   assign ca  = $signed({1'b0, a0});
   assign cb  = $signed({1'b0, b1});
   assign pa  = ca * x;          // first multiplier
   assign pb  = cb * state;      // second multiplier
   assign acc = (ACC_W'(pa) <<< GUARD) + ACC_W'(pb);
   assign shr = acc >>> COEF_W;

   always_comb begin
      if (shr > SMAX)      nxt = STATE_W'(SMAX);
      else if (shr < SMIN) nxt = STATE_W'(SMIN);
      else                 nxt = STATE_W'(shr);
   end

   always_ff @(posedge clk) begin
      if (rst || clr) state <= '0;
      else if (step)  state <= nxt;
   end

   assign y = state[STATE_W-1:GUARD];

   // R7: no step, no clear -> state holds
   p_state_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!step && !clr) |=> $stable(state));
   // R8: a clear leaves a zero state, even with a step in the same cycle
   p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
      clr |=> (state == '0));
endmodule

// File: rtl/lockin_demod.sv
module lockin_demod #(
   parameter int SAMPLE_W = 14,
   parameter int REF_W    = 16,
   parameter int FILT_W   = 16,
   parameter int GUARD    = 2,
   parameter int COEF_W   = 17,
   parameter int A0_INIT  = 65536,
   parameter int B1_INIT  = 65536
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     clr,
   input  logic                     in_valid,
   input  logic signed [SAMPLE_W-1:0] in_sample,
   input  logic [REF_W-1:0]         ref_i,
   input  logic [REF_W-1:0]         ref_q,
   input  logic                     cfg_we,
   input  logic [COEF_W-1:0]        cfg_a0,
   input  logic [COEF_W-1:0]        cfg_b1,
   output logic                     out_valid,
   output logic [FILT_W-1:0]        out_x,
   output logic [FILT_W-1:0]        out_y
);
   import lockin_pkg::*;

   localparam int STATE_W = FILT_W + GUARD;

   generate
      if (SAMPLE_W > HW_MUL_W || REF_W > HW_MUL_W) begin : g_bad_mix
         $error("lockin_demod: mixer operand exceeds hardware multiplier");
      end
      if (FILT_W > HW_MUL_W || STATE_W > HW_MUL_W || COEF_W + 1 > HW_MUL_W) begin : g_bad_filt
         $error("lockin_demod: filter operand exceeds hardware multiplier");
      end
      if (FILT_W > SAMPLE_W + REF_W || GUARD < 0) begin : g_bad_shape
         $error("lockin_demod: inconsistent filter widths");
      end
   endgenerate

   logic [NUM_CH*REF_W-1:0]  ref_bus;
   logic [NUM_CH*FILT_W-1:0] mix_bus, out_bus;
   logic                     mix_valid;
   logic [COEF_W-1:0]        a0_act, b1_act;

   assign ref_bus[CH_X*REF_W +: REF_W] = ref_i;
   assign ref_bus[CH_Y*REF_W +: REF_W] = ref_q;

   lockin_mixer #(
      .SAMPLE_W(SAMPLE_W), .REF_W(REF_W), .FILT_W(FILT_W), .NCH(NUM_CH)
   ) u_mix (
      .clk(clk), .rst(rst), .in_valid(in_valid), .sample(in_sample),
      .ref_bus(ref_bus), .mix_valid(mix_valid), .mix_bus(mix_bus)
   );

   lockin_coef_bank #(
      .COEF_W(COEF_W), .A0_INIT(A0_INIT), .B1_INIT(B1_INIT)
   ) u_coef (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_a0(cfg_a0), .cfg_b1(cfg_b1),
      .in_valid(in_valid), .a0_act(a0_act), .b1_act(b1_act)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_filt
         logic signed [FILT_W-1:0] y_c;
         lockin_iir #(
            .FILT_W(FILT_W), .COEF_W(COEF_W), .GUARD(GUARD)
         ) u_iir (
            .clk(clk), .rst(rst), .clr(clr), .step(mix_valid),
            .x($signed(mix_bus[c*FILT_W +: FILT_W])),
            .a0(a0_act), .b1(b1_act), .y(y_c)
         );
         assign out_bus[c*FILT_W +: FILT_W] = y_c;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= mix_valid;
   end

   assign out_x = out_bus[CH_X*FILT_W +: FILT_W];
   assign out_y = out_bus[CH_Y*FILT_W +: FILT_W];

   // R6: each accepted sample yields a strobe two edges later
   p_valid_latency_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##2 out_valid);
   // R6: no sample, no strobe two edges later
   p_valid_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> ##2 !out_valid);
   // R7: outputs move only on a strobe or after a clear
   p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(clr)) |-> ($stable(out_x) && $stable(out_y)));
endmodule

// File: tb/tb_lockin_demod.sv
module tb_lockin_demod;
   localparam int NV = 10;
   localparam longint SMAX = 131071;
   localparam longint SMIN = -131072;
   // stimulus table: sample, in-phase ref, quadrature ref; results come from the model below
   localparam int VS [NV] = '{ 8191, -8192,   4000, 0, -1,  1234,  -5000,   8191,   300, -8192};
   localparam int VI [NV] = '{32767, 12000, -32768, 5,  1,  -777, -20000, -32768, 32767, -32768};
   localparam int VQ [NV] = '{    0,-30000,  32767, 5, -1,  4321,  20000, -32768, 16384,  32767};

   logic clk = 1'b0;
   logic rst, clr, in_valid, cfg_we;
   logic signed [13:0] in_sample;
   logic [15:0] ref_i, ref_q;
   logic [16:0] cfg_a0, cfg_b1;
   logic out_valid;
   logic [15:0] out_x, out_y;

   int checks = 0;
   int errors = 0;
   longint mx = 0, my = 0, ma0 = 65536, mb1 = 65536;

   always #10 clk = ~clk;

   lockin_demod dut (
      .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_sample(in_sample),
      .ref_i(ref_i), .ref_q(ref_q), .cfg_we(cfg_we), .cfg_a0(cfg_a0), .cfg_b1(cfg_b1),
      .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
   );

   function automatic longint mixx(longint s, longint r);
      return (s * r) >>> 14;
   endfunction

   function automatic longint fstep(longint y, longint x, longint a0, longint b1);
      longint n;
      n = (a0 * x * 4 + b1 * y) >>> 17;
      if (n > SMAX) n = SMAX;
      if (n < SMIN) n = SMIN;
      return n;
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_out(string tag);
      chk(tag, longint'($signed(out_x)), mx >>> 2);
      chk(tag, longint'($signed(out_y)), my >>> 2);
   endtask

   task automatic send(string tag, int s, int ri, int rq, bit we, int wa0, int wb1);
      @(negedge clk);
      in_valid = 1'b1; in_sample = 14'(s); ref_i = 16'(ri); ref_q = 16'(rq);
      cfg_we = we; cfg_a0 = 17'(wa0); cfg_b1 = 17'(wb1);
      @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b0;
      chk("R6 strobe not yet", longint'(out_valid), 0);
      @(negedge clk);
      mx = fstep(mx, mixx(s, ri), ma0, mb1);
      my = fstep(my, mixx(s, rq), ma0, mb1);
      if (we) begin ma0 = wa0; mb1 = wb1; end
      chk("R6 strobe", longint'(out_valid), 1);
      chk_out(tag);
      @(negedge clk);
      chk("R6 single pulse", longint'(out_valid), 0);
   endtask

   task automatic write_pair(int wa0, int wb1);
      @(negedge clk);
      cfg_we = 1'b1; cfg_a0 = 17'(wa0); cfg_b1 = 17'(wb1);
      @(negedge clk);
      cfg_we = 1'b0;
      ma0 = wa0; mb1 = wb1;
   endtask

   initial begin
      #(200000 * 20);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; clr = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
      in_sample = '0; ref_i = '0; ref_q = '0; cfg_a0 = '0; cfg_b1 = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R5: reset state
      chk("R5 valid", longint'(out_valid), 0);
      chk_out("R5 outputs zero");

      // R1 R2 R5: table walk with the reset coefficient pair
      for (int k = 0; k < NV; k++)
         send("R1 R2 R5 table", VS[k], VI[k], VQ[k], 1'b0, 0, 0);

      // R7: other inputs wiggle without in_valid
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         in_sample = 14'(1000 * k - 3000); ref_i = 16'(7000 * k); ref_q = 16'(-5000 * k);
         chk_out("R7 hold");
      end

      // R4 R7: a write alone changes nothing until a sample arrives
      write_pair(16384, 114688);
      repeat (3) @(negedge clk);
      chk_out("R4 R7 deferred write");
      send("R4 new pair", 8000, 30000, -30000, 1'b0, 0, 0);
      send("R4 new pair", -6000, 25000, 12000, 1'b0, 0, 0);

      // R4: write in the same cycle as a sample -> that sample keeps the old pair
      send("R4 same cycle old pair", 5000, -20000, 20000, 1'b1, 98304, 32768);
      send("R4 following sample new pair", 5000, -20000, 20000, 1'b0, 0, 0);

      // R3: coefficients summing near 2 drive both channels into the rails
      write_pair(131071, 131071);
      for (int k = 0; k < 5; k++)
         send("R3 saturate", -8192, -32768, 32767, 1'b0, 0, 0);
      chk("R3 positive rail", longint'($signed(out_x)), 32767);
      chk("R3 negative rail", longint'($signed(out_y)), -32768);

      // R8: clear on its own
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      mx = 0; my = 0;
      chk_out("R8 clear");

      // R8: clear wins over a step in the same cycle
      send("R8 restart", 4000, 16000, -16000, 1'b0, 0, 0);
      @(negedge clk);
      in_valid = 1'b1; in_sample = 14'(7000); ref_i = 16'(30000); ref_q = 16'(30000);
      @(negedge clk);
      in_valid = 1'b0; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      mx = 0; my = 0;
      chk("R8 strobe kept", longint'(out_valid), 1);
      chk_out("R8 clear over step");

      // R1 R2: a fresh sample after the clear
      send("R1 R2 after clear", -3000, 9000, -9000, 1'b0, 0, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule